// File: doc/BRIEF.md
# Floating-Point Control Register Alias Unit

This block keeps the control and status word of a floating-point unit, along with a constant word that identifies the implementation. Software uses move-from and move-to control operations to reach this state. Each operation carries a 5-bit register number.

The number selects one of the following:
- the identification word;
- the full 32-bit status word;
- one of three compact views.

Each compact view gathers a subset of the status fields into a short layout. A write through a view changes only the fields that view exposes, and every other status bit keeps its value.

The unit also drives these outputs to the arithmetic datapath:
- the current rounding mode;
- the eight condition bits;
- the flush-to-zero control.

Reads are combinational from the stored state. Writes take effect at the clock edge. An access to an unused register number is refused and is reported by a one-cycle error pulse.

Top module: `fcr_alias_unit`

## Requirements
- R1: After reset the status word is zero: full-view reads return 0, round_mode, cond_bits and flush_en are 0, and err_pulse is 0.
- R2: A read of number 0 returns the parameter IMPL_WORD. A write to number 0 changes no status bit and raises no error.
- R3: Number 31 reads the whole status word and a write there replaces all 32 bits.
- R4: A read of number 25 returns status bits 31:25 in result bits 7:1 and status bit 23 in result bit 0, with result bits 31:8 zero.
- R5: A write to number 25 loads status bits 31:25 from data bits 7:1 and leaves all other status bits, including bit 23, unchanged.
- R6: A read of number 26 returns the status word ANDed with 0x0003F07C (cause bits 17:12, flag bits 6:2).
- R7: A write to number 26 replaces only status bits 17:12 and 6:2 with the same data bits.
- R8: A read of number 28 returns enables (status 11:7) in bits 11:7, flush (status 24) in bit 2 and rounding mode (status 1:0) in bits 1:0, all other bits zero.
- R9: A write to number 28 loads status 11:7 from data 11:7, status 24 from data bit 2 and status 1:0 from data 1:0, and preserves every other status bit.
- R10: round_mode always equals status 1:0. cond_bits equals {status 31:25, status 23}. flush_en equals status 24.
- R11: Any number other than 0, 25, 26, 28 and 31 reads as 0 and its writes are ignored. An access to such a number (read or write) sets err_pulse high for exactly the next cycle.
- R12: When a read and a write occur in the same cycle, the read returns the value before the write, and the new value is visible from the next cycle.

Valid register numbers are 0, 25, 26, 28 and 31. rd_data is 0 whenever rd_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read access this cycle |
| wr_req | input | 1 | Write access this cycle |
| acc_idx | input | 5 | Control register number |
| wr_data | input | 32 | Data for a write |
| rd_data | output | 32 | Read result, combinational |
| round_mode | output | 2 | Current rounding mode |
| cond_bits | output | 8 | Condition bits {status 31:25, status 23} |
| flush_en | output | 1 | Flush-to-zero control |
| err_pulse | output | 1 | One-cycle pulse after an access to an unused number |

## Verification
The status word is first loaded through the full view with complementary alternating patterns, so that any swapped or misplaced bit in a view's packing shows up. Each compact view is then written with all-ones and all-zeros data. This separates bits that the view must change from bits it must preserve, including status bit 23, which is readable but not writable through number 25. Same-cycle read-with-write cases tell a pre-write read from a bypassed one. A long pseudo-random mix of valid and unused numbers, with simultaneous reads and writes, compares every output against the reference model on every clock.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

    localparam int IDX_W  = 5;
    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // register numbers decoded by the unit
    localparam idx_t NUM_IDENT = 5'd0;
    localparam idx_t NUM_CCV   = 5'd25;
    localparam idx_t NUM_EXCV  = 5'd26;
    localparam idx_t NUM_ENAV  = 5'd28;
    localparam idx_t NUM_FULL  = 5'd31;

    // status word field positions
    localparam int RM_LO    = 0;
    localparam int RM_HI    = 1;
    localparam int FLG_LO   = 2;
    localparam int FLG_HI   = 6;
    localparam int ENA_LO   = 7;
    localparam int ENA_HI   = 11;
    localparam int CAU_LO   = 12;
    localparam int CAU_HI   = 17;
    localparam int CC0_BIT  = 23;
    localparam int FLUSH_BIT = 24;
    localparam int CCH_LO   = 25;
    localparam int CCH_HI   = 31;

    localparam int RM_W   = RM_HI - RM_LO + 1;
    localparam int CCH_W  = CCH_HI - CCH_LO + 1;
    localparam int CC_W   = CCH_W + 1;

    // compact view layout positions
    localparam int V25_CCH_LO = 1;
    localparam int V28_FLUSH  = 2;

    typedef enum logic [2:0] {
        VIEW_IDENT,
        VIEW_CC,
        VIEW_EXC,
        VIEW_ENA,
        VIEW_FULL,
        VIEW_BAD
    } view_sel_e;

    typedef struct packed {
        word_t stat;
        logic  err;
    } fcr_state_t;

endpackage

// File: rtl/fcr_index_decode.sv
module fcr_index_decode
    import fcr_pkg::*;
(
    input  idx_t      num,
    output view_sel_e sel
);

    always_comb begin
        unique case (num)
            NUM_IDENT: sel = VIEW_IDENT;
            NUM_CCV:   sel = VIEW_CC;
            NUM_EXCV:  sel = VIEW_EXC;
            NUM_ENAV:  sel = VIEW_ENA;
            NUM_FULL:  sel = VIEW_FULL;
            default:   sel = VIEW_BAD;
        endcase
    end

endmodule

// File: rtl/fcr_view_pack.sv
module fcr_view_pack
    import fcr_pkg::*;
#(
    parameter word_t IDENT = '0
) (
    input  word_t     stat,
    input  view_sel_e sel,
    output word_t     view
);

    word_t cc_view;
    word_t exc_view;
    word_t ena_view;

    always_comb begin
        cc_view = '0;
        cc_view[0] = stat[CC0_BIT];
        cc_view[V25_CCH_LO +: CCH_W] = stat[CCH_HI:CCH_LO];
    end

    always_comb begin
        exc_view = '0;
        exc_view[CAU_HI:CAU_LO] = stat[CAU_HI:CAU_LO];
        exc_view[FLG_HI:FLG_LO] = stat[FLG_HI:FLG_LO];
    end

    always_comb begin
        ena_view = '0;
        ena_view[ENA_HI:ENA_LO] = stat[ENA_HI:ENA_LO];
        ena_view[V28_FLUSH]     = stat[FLUSH_BIT];
        ena_view[RM_HI:RM_LO]   = stat[RM_HI:RM_LO];
    end

    always_comb begin
        unique case (sel)
            VIEW_IDENT: view = IDENT;
            VIEW_CC:    view = cc_view;
            VIEW_EXC:   view = exc_view;
            VIEW_ENA:   view = ena_view;
            VIEW_FULL:  view = stat;
            default:    view = '0;
        endcase
    end

endmodule

// File: rtl/fcr_view_merge.sv
module fcr_view_merge
    import fcr_pkg::*;
(
    input  word_t     stat,
    input  view_sel_e sel,
    input  word_t     wdata,
    output word_t     merged
);

    word_t from_cc;
    word_t from_exc;
    word_t from_ena;

    always_comb begin
        from_cc = stat;
        from_cc[CCH_HI:CCH_LO] = wdata[V25_CCH_LO +: CCH_W];
    end

    always_comb begin
        from_exc = stat;
        from_exc[CAU_HI:CAU_LO] = wdata[CAU_HI:CAU_LO];
        from_exc[FLG_HI:FLG_LO] = wdata[FLG_HI:FLG_LO];
    end

    always_comb begin
        from_ena = stat;
        from_ena[ENA_HI:ENA_LO] = wdata[ENA_HI:ENA_LO];
        from_ena[FLUSH_BIT]     = wdata[V28_FLUSH];
        from_ena[RM_HI:RM_LO]   = wdata[RM_HI:RM_LO];
    end

    always_comb begin
        unique case (sel)
            VIEW_CC:   merged = from_cc;
            VIEW_EXC:  merged = from_exc;
            VIEW_ENA:  merged = from_ena;
            VIEW_FULL: merged = wdata;
            default:   merged = stat;
        endcase
    end

endmodule

// File: rtl/fcr_alias_unit.sv
module fcr_alias_unit
    import fcr_pkg::*;
#(
    parameter logic [31:0] IMPL_WORD = 32'h0003_0A01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_req,
    input  logic        wr_req,
    input  logic [4:0]  acc_idx,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic [1:0]  round_mode,
    output logic [7:0]  cond_bits,
    output logic        flush_en,
    output logic        err_pulse
);

    fcr_state_t st_d;
    fcr_state_t st_q;
    view_sel_e  sel;
    word_t      packed_view;
    word_t      merged_word;

    fcr_index_decode u_dec (
        .num (acc_idx),
        .sel (sel)
    );

    fcr_view_pack #(.IDENT(IMPL_WORD)) u_pack (
        .stat (st_q.stat),
        .sel  (sel),
        .view (packed_view)
    );

    fcr_view_merge u_merge (
        .stat   (st_q.stat),
        .sel    (sel),
        .wdata  (wr_data),
        .merged (merged_word)
    );

    always_comb begin
        st_d = st_q;
        if (wr_req) begin
            st_d.stat = merged_word;
        end
        st_d.err = (rd_req || wr_req) && (sel == VIEW_BAD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data    = rd_req ? packed_view : '0;
    assign round_mode = st_q.stat[RM_HI:RM_LO];
    assign flush_en   = st_q.stat[FLUSH_BIT];
    assign err_pulse  = st_q.err;

    assign cond_bits[0] = st_q.stat[CC0_BIT];
    for (genvar gi = 0; gi < CCH_W; gi++) begin : g_cc
        assign cond_bits[gi + 1] = st_q.stat[CCH_LO + gi];
    end

endmodule

// File: rtl/fcr_alias_chk.sv
module fcr_alias_chk #(
    parameter logic [31:0] IMPL_WORD = 32'h0003_0A01
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_req,
    input logic        wr_req,
    input logic [4:0]  acc_idx,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic [1:0]  round_mode,
    input logic [7:0]  cond_bits,
    input logic        flush_en,
    input logic        err_pulse
);

    logic unused_num;
    assign unused_num = !(acc_idx == 5'd0 || acc_idx == 5'd25 || acc_idx == 5'd26 ||
                          acc_idx == 5'd28 || acc_idx == 5'd31);

    assert_ident_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && acc_idx == 5'd0) |-> rd_data == IMPL_WORD);

    assert_ident_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && acc_idx == 5'd0) |=> ($stable(round_mode) && $stable(cond_bits) && $stable(flush_en)));

    assert_full_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && acc_idx == 5'd31) |=>
            (round_mode == $past(wr_data[1:0]) &&
             cond_bits == {$past(wr_data[31:25]), $past(wr_data[23])} &&
             flush_en == $past(wr_data[24])));

    assert_cc_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && acc_idx == 5'd25) |=>
            (cond_bits[7:1] == $past(wr_data[7:1]) && $stable(cond_bits[0]) &&
             $stable(round_mode) && $stable(flush_en)));

    assert_exc_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && acc_idx == 5'd26) |=>
            ($stable(round_mode) && $stable(cond_bits) && $stable(flush_en)));

    assert_ena_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && acc_idx == 5'd28) |=>
            (round_mode == $past(wr_data[1:0]) && flush_en == $past(wr_data[2]) &&
             $stable(cond_bits)));

    assert_bad_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_req || wr_req) && unused_num) |=> err_pulse);

    assert_no_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !((rd_req || wr_req) && unused_num) |=> !err_pulse);

    assert_bad_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && unused_num) |-> rd_data == 32'd0);

    assert_bad_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && unused_num) |=> ($stable(round_mode) && $stable(cond_bits) && $stable(flush_en)));

endmodule

bind fcr_alias_unit fcr_alias_chk #(.IMPL_WORD(IMPL_WORD)) u_chk (.*);

// File: tb/fcr_alias_unit_bench.sv
`timescale 1ns/1ps
module fcr_alias_unit_bench;

    localparam logic [31:0] IMPL = 32'h0003_0A01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic        wr_req = 1'b0;
    logic [4:0]  acc_idx = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [1:0]  round_mode;
    logic [7:0]  cond_bits;
    logic        flush_en;
    logic        err_pulse;

    int checks = 0;
    int fails = 0;

    logic [31:0] m_stat = '0;
    logic        m_err = 1'b0;

    always #2.5 clk = ~clk;

    fcr_alias_unit #(.IMPL_WORD(IMPL)) u_fcr_alias_unit (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .acc_idx(acc_idx), .wr_data(wr_data), .rd_data(rd_data),
        .round_mode(round_mode), .cond_bits(cond_bits),
        .flush_en(flush_en), .err_pulse(err_pulse)
    );

    function automatic bit is_known(input int n);
        return (n == 0 || n == 25 || n == 26 || n == 28 || n == 31);
    endfunction

    function automatic logic [31:0] ref_read(input int n, input logic [31:0] s);
        case (n)
            0:  return IMPL;
            25: return ((s >> 24) & 32'hFE) | ((s >> 23) & 32'h1);
            26: return s & 32'h0003_F07C;
            28: return (s & 32'hF80) | ((s >> 22) & 32'h4) | (s & 32'h3);
            31: return s;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] ref_write(input int n, input logic [31:0] s, input logic [31:0] v);
        case (n)
            25: return (s & ~32'hFE00_0000) | ((v & 32'hFE) << 24);
            26: return (s & ~32'h0003_F07C) | (v & 32'h0003_F07C);
            28: return (s & ~32'h0100_0F83) | (v & 32'hF83) | ((v & 32'h4) << 22);
            31: return v;
            default: return s;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: drive at falling edge, compare before rising edge, advance model
    task automatic step(input bit rd, input bit wr, input int n, input logic [31:0] v, input string tag);
        logic [31:0] exp_rd;
        @(negedge clk);
        rd_req = rd; wr_req = wr; acc_idx = 5'(n); wr_data = v;
        #1;
        exp_rd = rd ? ref_read(n, m_stat) : 32'h0;
        chk(rd_data == exp_rd, tag, "rd_data", rd_data, exp_rd);
        chk(round_mode == m_stat[1:0], "R10", "round_mode", 32'(round_mode), 32'(m_stat[1:0]));
        chk(cond_bits == {m_stat[31:25], m_stat[23]}, "R10", "cond_bits",
            32'(cond_bits), 32'({m_stat[31:25], m_stat[23]}));
        chk(flush_en == m_stat[24], "R10", "flush_en", 32'(flush_en), 32'(m_stat[24]));
        chk(err_pulse == m_err, "R11", "err_pulse", 32'(err_pulse), 32'(m_err));
        @(posedge clk);
        if (rst_n) begin
            m_err = (rd || wr) && !is_known(n);
            if (wr) m_stat = ref_write(n, m_stat, v);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        // R1: reset state
        step(1, 0, 31, 32'h0, "R1");
        step(1, 0, 31, 32'h0, "R1");
        rst_n = 1'b1;
        step(1, 0, 31, 32'h0, "R1");
        // R2: identification word, read-only
        step(1, 0, 0, 32'h0, "R2");
        step(0, 1, 0, 32'hFFFF_FFFF, "R2");
        step(1, 0, 31, 32'h0, "R2");
        // R3: full view
        step(0, 1, 31, 32'hA5A5_A5A5, "R3");
        step(1, 0, 31, 32'h0, "R3");
        // R4, R6, R8: packed reads of two complementary patterns
        step(1, 0, 25, 32'h0, "R4");
        step(1, 0, 26, 32'h0, "R6");
        step(1, 0, 28, 32'h0, "R8");
        step(0, 1, 31, 32'h5A5A_5A5A, "R3");
        step(1, 0, 25, 32'h0, "R4");
        step(1, 0, 26, 32'h0, "R6");
        step(1, 0, 28, 32'h0, "R8");
        // R5: cc view write, bit 23 and others kept
        step(0, 1, 25, 32'hFFFF_FFFF, "R5");
        step(1, 0, 31, 32'h0, "R5");
        step(0, 1, 25, 32'h0, "R5");
        step(1, 0, 31, 32'h0, "R5");
        // R7: exception view write
        step(0, 1, 26, 32'hFFFF_FFFF, "R7");
        step(1, 0, 31, 32'h0, "R7");
        step(0, 1, 26, 32'h0, "R7");
        step(1, 0, 31, 32'h0, "R7");
        // R9: enables view write
        step(0, 1, 28, 32'hFFFF_FFFF, "R9");
        step(1, 0, 31, 32'h0, "R9");
        step(0, 1, 28, 32'h0000_0006, "R9");
        step(1, 0, 28, 32'h0, "R9");
        // R12: read and write in the same cycle
        step(1, 1, 31, 32'h1234_5679, "R12");
        step(1, 0, 31, 32'h0, "R12");
        step(1, 1, 28, 32'h0000_0001, "R12");
        step(1, 0, 28, 32'h0, "R12");
        // R11: unused numbers
        step(1, 1, 30, 32'hFFFF_FFFF, "R11");
        step(1, 0, 31, 32'h0, "R11");
        step(0, 1, 1, 32'h0, "R11");
        step(0, 0, 1, 32'h0, "R11");
        step(1, 0, 27, 32'h0, "R11");
        step(1, 0, 24, 32'h0, "R11");
        step(0, 0, 0, 32'h0, "R11");
        // mixed traffic
        lfsr = 32'hACE1_1234;
        for (int k = 0; k < 400; k++) begin
            int pick;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            pick = int'(lfsr[2:0]);
            case (pick)
                0: step(lfsr[3], lfsr[4], 0,  lfsr ^ 32'h9E37_79B9, "R2");
                1: step(lfsr[3], lfsr[4], 25, lfsr ^ 32'h9E37_79B9, "R5");
                2: step(lfsr[3], lfsr[4], 26, lfsr ^ 32'h9E37_79B9, "R7");
                3: step(lfsr[3], lfsr[4], 28, lfsr ^ 32'h9E37_79B9, "R9");
                4: step(lfsr[3], lfsr[4], 31, lfsr ^ 32'h9E37_79B9, "R3");
                default: step(lfsr[3], lfsr[4], int'(lfsr[9:5]), lfsr, "R12");
            endcase
        end
        step(0, 0, 0, 32'h0, "R11");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule